// File: doc/BRIEF.md
# Effective Address Sequencer

This unit works out the effective address of a memory operand for an 8-bit processor that has a 16-bit address bus. It advances one bus access per clock. When `start` is pulsed while the unit is idle, it captures the addressing mode, the operation class, the program counter and both index registers. It then reads operand bytes at the program counter, adds an index where the mode asks for one, and follows pointers held in page zero. It also issues the dummy reads that the real bus performs.

For read-modify-write operations the unit reads the operand into a buffer and writes that same value back before it hands over. At the end it raises a one-cycle execute strobe. Alongside the strobe it presents the final address, the operand buffer, the advanced program counter and the unindexed high byte of the base. The execute stage takes over from there.

Memory is expected to answer a read combinationally in the same cycle.

Top module: `ea_sequencer`

## Requirements
- R1: After reset the unit is idle: `bus_rd`, `bus_wr` and `exec_stb` are low and `ea_out` is 0.
- R2: `start` is accepted only when idle. Mode codes are 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 pre-indexed indirect (X), 7 post-indexed indirect (Y). Class codes are 0 read, 1 write, 2 read-modify-write. Operand bytes are read at consecutive program-counter addresses, and `pc_out` at the strobe equals the start PC plus the number of operand bytes.
- R3: Zero-page indexed modes read the base byte, then do a dummy read at {0x00, base}. The address is {0x00, (base+index) mod 256}.
- R4: Absolute mode reads the low byte, then the high byte, and the address is {high, low}.
- R5: An absolute or post-indexed read-class access whose low-byte sum stays below 0x100 strobes the cycle right after the high-byte read, with no dummy read.
- R6: When the low-byte sum reaches 0x100, a dummy read is issued at {high, sum mod 256}. The final address is that value plus 0x100, wrapping modulo 0x10000.
- R7: Write and read-modify-write classes in indexed absolute or post-indexed modes always perform the dummy read at {high, sum mod 256}, even without a page cross.
- R8: Pre-indexed indirect reads the pointer, does a dummy read at {0x00, pointer}, then reads the low byte at (pointer+X) mod 256 and the high byte at (pointer+X+1) mod 256 in page zero.
- R9: Post-indexed indirect reads the pointer, then the low byte at {0x00, pointer} and the high byte at {0x00, (pointer+1) mod 256}. It then applies Y with the R5/R6/R7 rules.
- R10: Read-modify-write reads the final address into `rd_buf`, writes the same byte back to the same address in the next cycle, and strobes in the cycle after that.
- R11: At the strobe `base_hi` holds the high byte as fetched, before any carry. It is 0 for the zero-page modes.
- R12: `exec_stb` is high for exactly one cycle, with no bus access in that cycle. The unit is idle in the next cycle, and a `start` raised while busy does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new address sequence (idle only) |
| mode | input | 3 | Addressing mode code |
| op_class | input | 2 | Operation class code |
| pc_in | input | 16 | Program counter at the first operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| bus_rdata | input | 8 | Read data, valid in the same cycle as the address |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read access this cycle |
| bus_wr | output | 1 | Write access this cycle |
| bus_wdata | output | 8 | Write data |
| exec_stb | output | 1 | One-cycle hand-over strobe |
| ea_out | output | 16 | Effective address |
| base_hi | output | 8 | Fetched high byte of the base |
| rd_buf | output | 8 | Operand read by a read-modify-write |
| pc_out | output | 16 | Program counter after the operand bytes |

## Verification
The cases are chosen in pairs that differ in one thing. Absolute-indexed reads are run with and without a carry out of the low byte, which separates the skipped dummy cycle from the taken one. The same no-carry addresses are then repeated with the write and read-modify-write classes, so a design that keys the penalty on the carry alone shows up. Pointers of 0xFE and 0xFF, and a base of 0xFFFF, push every wrap at a page or address boundary: page-zero pointer increment, zero-page index and 16-bit carry. A `start` pulse in the middle of a sequence shows whether a busy unit can be restarted.

// File: rtl/ea_pkg.sv
// Shared types for the effective address sequencer.
// Assumes: mode and class codes match the brief; state order is free.
package ea_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_FLO, S_FHI, S_ZIDX, S_PTR, S_PDUM,
        S_PLO, S_PHI, S_FIX, S_RMWR, S_RMWW, S_EXEC
    } seq_state_t;

    localparam logic [2:0] AM_ZP   = 3'd0;
    localparam logic [2:0] AM_ZPX  = 3'd1;
    localparam logic [2:0] AM_ZPY  = 3'd2;
    localparam logic [2:0] AM_ABS  = 3'd3;
    localparam logic [2:0] AM_ABSX = 3'd4;
    localparam logic [2:0] AM_ABSY = 3'd5;
    localparam logic [2:0] AM_INDX = 3'd6;
    localparam logic [2:0] AM_INDY = 3'd7;

    localparam logic [1:0] CL_READ = 2'd0;
    localparam logic [1:0] CL_RMW  = 2'd2;
endpackage

// File: rtl/ea_lowadd.sv
// Low-byte index adder: sum modulo 2^DW plus carry out.
// Assumes: the caller decides whether the carry matters.
module ea_lowadd #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry
);
    // widened add so the carry is kept
    assign {carry, sum} = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/ea_busmux.sv
// Bus request decode: maps the sequencer state to one bus access.
// Assumes: at most one access per cycle; the strobe state uses no bus.
module ea_busmux
    import ea_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  seq_state_t    st,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] buf_val,
    output logic [AW-1:0] addr,
    output logic          rd,
    output logic          wr,
    output logic [DW-1:0] wdata,
    output logic          exec
);
    localparam logic [DW-1:0] ZPAGE = '0;
    localparam logic [DW-1:0] ONE   = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] ptr_nx;
    assign ptr_nx = ptr + ONE;

    // select address and access kind for the current state
    always_comb begin
        addr  = '0;
        rd    = 1'b0;
        wr    = 1'b0;
        exec  = 1'b0;
        wdata = buf_val;
        unique case (st)
            S_FLO, S_FHI, S_PTR: begin addr = pc;              rd = 1'b1; end
            S_ZIDX:              begin addr = {ZPAGE, lo};     rd = 1'b1; end
            S_PDUM, S_PLO:       begin addr = {ZPAGE, ptr};    rd = 1'b1; end
            S_PHI:               begin addr = {ZPAGE, ptr_nx}; rd = 1'b1; end
            S_FIX, S_RMWR:       begin addr = {hi, lo};        rd = 1'b1; end
            S_RMWW:              begin addr = {hi, lo};        wr = 1'b1; end
            S_EXEC:              begin addr = {hi, lo};        exec = 1'b1; end
            default:             begin addr = '0; end
        endcase
    end
endmodule

// File: rtl/ea_sequencer.sv
// Effective address sequencer: steps through operand fetch, indexing,
// pointer following, dummy reads and the read-modify-write echo, then
// strobes the execute stage with the final address.
// Assumes: bus_rdata answers combinationally to bus_addr in the same cycle.
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [1:0]    op_class,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          exec_stb,
    output logic [AW-1:0] ea_out,
    output logic [DW-1:0] base_hi,
    output logic [DW-1:0] rd_buf,
    output logic [AW-1:0] pc_out
);
    localparam logic [AW-1:0] PC_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] B_ONE  = {{(DW-1){1'b0}}, 1'b1};

    seq_state_t    st;
    logic [2:0]    mode_r;
    logic [1:0]    cls_r;
    logic [AW-1:0] pc_r;
    logic [DW-1:0] x_r, y_r, lo_r, hi_r, ptr_r, buf_r, bh_r;
    logic          carry_r;

    logic          use_y, indexed;
    logic [DW-1:0] idx_sel, add_sum;
    logic          add_c;
    seq_state_t    tail_st;

    // index source and whether the absolute/post-indexed add applies
    always_comb begin
        use_y   = (mode_r == AM_ZPY) || (mode_r == AM_ABSY) || (mode_r == AM_INDY);
        indexed = (mode_r == AM_ABSX) || (mode_r == AM_ABSY) || (mode_r == AM_INDY);
        idx_sel = use_y ? y_r : x_r;
        tail_st = (cls_r == CL_RMW) ? S_RMWR : S_EXEC;
    end

    ea_lowadd #(.DW(DW)) u_add (
        .a(lo_r), .b(idx_sel), .sum(add_sum), .carry(add_c)
    );

    ea_busmux #(.DW(DW)) u_mux (
        .st(st), .pc(pc_r), .lo(lo_r), .hi(hi_r), .ptr(ptr_r), .buf_val(buf_r),
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata), .exec(exec_stb)
    );

    // sequencer state and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            mode_r  <= '0;
            cls_r   <= '0;
            pc_r    <= '0;
            x_r     <= '0;
            y_r     <= '0;
            lo_r    <= '0;
            hi_r    <= '0;
            ptr_r   <= '0;
            buf_r   <= '0;
            bh_r    <= '0;
            carry_r <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    mode_r  <= mode;
                    cls_r   <= op_class;
                    pc_r    <= pc_in;
                    x_r     <= idx_x;
                    y_r     <= idx_y;
                    lo_r    <= '0;
                    hi_r    <= '0;
                    bh_r    <= '0;
                    carry_r <= 1'b0;
                    st      <= (mode == AM_INDX || mode == AM_INDY) ? S_PTR : S_FLO;
                end
                S_FLO: begin
                    lo_r <= bus_rdata;
                    pc_r <= pc_r + PC_ONE;
                    if (mode_r == AM_ZP)                          st <= tail_st;
                    else if (mode_r == AM_ZPX || mode_r == AM_ZPY) st <= S_ZIDX;
                    else                                          st <= S_FHI;
                end
                S_ZIDX: begin
                    lo_r <= add_sum;
                    st   <= tail_st;
                end
                S_FHI, S_PHI: begin
                    hi_r <= bus_rdata;
                    bh_r <= bus_rdata;
                    if (st == S_FHI) pc_r <= pc_r + PC_ONE;
                    if (indexed) begin
                        lo_r    <= add_sum;
                        carry_r <= add_c;
                        st      <= (add_c || cls_r != CL_READ) ? S_FIX : tail_st;
                    end else begin
                        st <= tail_st;
                    end
                end
                S_PTR: begin
                    ptr_r <= bus_rdata;
                    pc_r  <= pc_r + PC_ONE;
                    st    <= (mode_r == AM_INDX) ? S_PDUM : S_PLO;
                end
                S_PDUM: begin
                    ptr_r <= ptr_r + x_r;
                    st    <= S_PLO;
                end
                S_PLO: begin
                    lo_r <= bus_rdata;
                    st   <= S_PHI;
                end
                S_FIX: begin
                    if (carry_r) hi_r <= hi_r + B_ONE;
                    carry_r <= 1'b0;
                    st      <= tail_st;
                end
                S_RMWR: begin
                    buf_r <= bus_rdata;
                    st    <= S_RMWW;
                end
                S_RMWW:  st <= S_EXEC;
                S_EXEC:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign ea_out  = {hi_r, lo_r};
    assign base_hi = bh_r;
    assign rd_buf  = buf_r;
    assign pc_out  = pc_r;

    // R10: the echo write goes to the address read one cycle before
    a_r10_echo_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ($past(bus_rd) && bus_addr == $past(bus_addr)));

    // R10: the echo write carries the byte that was read
    a_r10_echo_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_wdata == $past(bus_rdata));

    // R12: strobe lasts one cycle and is followed by an idle bus
    a_r12_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> (!exec_stb && !bus_rd && !bus_wr));

    // R12: never more than one of read, write, strobe
    a_r12_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr, exec_stb}));

    // R6: a carried dummy read is followed by a high byte one above it
    a_r6_carry_page: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FIX && carry_r) |=>
            ea_out[AW-1:DW] == $past(bus_addr[AW-1:DW]) + B_ONE);

    // R3: zero-page indexing leaves the address in page zero
    a_r3_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ZIDX) |=> ea_out[AW-1:DW] == '0);
endmodule

// File: tb/sim_ea_sequencer.sv
module sim_ea_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  op_class = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  idx_x = '0, idx_y = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr, ea_out, pc_out;
    logic        bus_rd, bus_wr, exec_stb;
    logic [7:0]  bus_wdata, base_hi, rd_buf;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ea_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_class(op_class),
        .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .exec_stb(exec_stb), .ea_out(ea_out), .base_hi(base_hi), .rd_buf(rd_buf),
        .pc_out(pc_out)
    );

    // memory: a computed background plus a few patched bytes
    logic [15:0] p_a [8];
    logic [7:0]  p_v [8];
    logic        p_en [8];

    function automatic logic [7:0] bg(input logic [15:0] a);
        return 8'(a[7:0] * 5 + a[15:8] * 3 + 8'h11);
    endfunction

    function automatic logic [7:0] mrd(input logic [15:0] a);
        logic [7:0] v;
        v = bg(a);
        for (int i = 0; i < 8; i++) if (p_en[i] && p_a[i] == a) v = p_v[i];
        return v;
    endfunction

    always_comb begin
        bus_rdata = bg(bus_addr);
        for (int i = 0; i < 8; i++) if (p_en[i] && p_a[i] == bus_addr) bus_rdata = p_v[i];
    end

    task automatic clr_patch();
        for (int i = 0; i < 8; i++) begin p_en[i] = 1'b0; p_a[i] = '0; p_v[i] = '0; end
    endtask

    task automatic patch(input int i, input int a, input int v);
        p_en[i] = 1'b1; p_a[i] = 16'(a); p_v[i] = 8'(v);
    endtask

    // expected per-cycle activity: kind 0 read, 1 write, 2 strobe
    int q_k[$], q_a[$], q_d[$], q_p[$], q_h[$];

    task automatic push(input int k, input int a, input int d, input int p, input int h);
        q_k.push_back(k); q_a.push_back(a & 16'hFFFF); q_d.push_back(d);
        q_p.push_back(p & 16'hFFFF); q_h.push_back(h);
    endtask

    task automatic model(input int md, input int cl, input int pc, input int x, input int y);
        int p, lo, hi, ptr, q, s, ea, bh, bf, idx, b;
        p = pc; bh = 0; bf = -1; ea = 0;
        idx = (md == 2 || md == 5 || md == 7) ? y : x;
        case (md)
            0: begin ea = mrd(16'(p)); push(0, p, 0, 0, 0); p++; end
            1, 2: begin
                b = mrd(16'(p)); push(0, p, 0, 0, 0); p++;
                push(0, b, 0, 0, 0); ea = (b + idx) & 255;
            end
            3, 4, 5: begin
                lo = mrd(16'(p)); push(0, p, 0, 0, 0); p++;
                hi = mrd(16'(p)); push(0, p, 0, 0, 0); p++;
                bh = hi; ea = hi * 256 + lo;
                if (md != 3) begin
                    s = lo + idx; ea = hi * 256 + (s & 255);
                    if (s > 255 || cl != 0) begin
                        push(0, ea, 0, 0, 0);
                        if (s > 255) ea = (ea + 256) & 16'hFFFF;
                    end
                end
            end
            6: begin
                ptr = mrd(16'(p)); push(0, p, 0, 0, 0); p++;
                push(0, ptr, 0, 0, 0);
                q = (ptr + x) & 255;
                lo = mrd(16'(q)); push(0, q, 0, 0, 0);
                hi = mrd(16'((q + 1) & 255)); push(0, (q + 1) & 255, 0, 0, 0);
                bh = hi; ea = hi * 256 + lo;
            end
            default: begin
                ptr = mrd(16'(p)); push(0, p, 0, 0, 0); p++;
                lo = mrd(16'(ptr)); push(0, ptr, 0, 0, 0);
                hi = mrd(16'((ptr + 1) & 255)); push(0, (ptr + 1) & 255, 0, 0, 0);
                bh = hi; s = lo + idx; ea = hi * 256 + (s & 255);
                if (s > 255 || cl != 0) begin
                    push(0, ea, 0, 0, 0);
                    if (s > 255) ea = (ea + 256) & 16'hFFFF;
                end
            end
        endcase
        if (cl == 2) begin
            bf = mrd(16'(ea)); push(0, ea, 0, 0, 0); push(1, ea, bf, 0, 0);
        end
        push(2, ea, bf, p, bh);
    endtask

    task automatic check_idle(input string tag);
        total++;
        if (bus_rd || bus_wr || exec_stb) begin
            bad++;
            $display("FAIL %s idle: rd=%b wr=%b ex=%b expected 0 0 0", tag, bus_rd, bus_wr, exec_stb);
        end
    endtask

    task automatic run_case(input int md, input int cl, input int pc, input int x, input int y,
                            input string tag, input bit poke);
        int k, a, d, p, h, step;
        bit ok;
        model(md, cl, pc, x, y);
        @(negedge clk);
        start = 1'b1; mode = 3'(md); op_class = 2'(cl); pc_in = 16'(pc);
        idx_x = 8'(x); idx_y = 8'(y);
        @(negedge clk);
        start = 1'b0;
        step = 0;
        while (q_k.size() > 0) begin
            k = q_k.pop_front(); a = q_a.pop_front(); d = q_d.pop_front();
            p = q_p.pop_front(); h = q_h.pop_front();
            if (k == 0)
                ok = bus_rd && !bus_wr && !exec_stb && bus_addr == 16'(a);
            else if (k == 1)
                ok = bus_wr && !bus_rd && !exec_stb && bus_addr == 16'(a) && bus_wdata == 8'(d);
            else
                ok = exec_stb && !bus_rd && !bus_wr && ea_out == 16'(a) && pc_out == 16'(p)
                     && base_hi == 8'(h) && (d < 0 || rd_buf == 8'(d));
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s step %0d: rd=%b wr=%b ex=%b addr=%h wd=%h ea=%h pc=%h bh=%h buf=%h expected kind=%0d addr=%h data=%0d pc=%h bh=%h",
                         tag, step, bus_rd, bus_wr, exec_stb, bus_addr, bus_wdata, ea_out,
                         pc_out, base_hi, rd_buf, k, a, d, p, h);
            end
            if (poke && step == 1) begin start = 1'b1; pc_in = 16'h1234; mode = 3'd0; end
            if (poke && step == 2) start = 1'b0;
            step++;
            @(negedge clk);
        end
        check_idle({tag, " R12"});
    endtask

    // watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL R12 watchdog expired: cycles=%0d expected below 50000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr_patch();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        total++;
        if (bus_rd || bus_wr || exec_stb || ea_out != 16'h0000) begin
            bad++;
            $display("FAIL R1 reset: rd=%b wr=%b ex=%b ea=%h expected 0 0 0 0000",
                     bus_rd, bus_wr, exec_stb, ea_out);
        end
        // R2 R4: absolute read
        clr_patch(); patch(0, 16'h0400, 8'h34); patch(1, 16'h0401, 8'h12);
        run_case(3, 0, 16'h0400, 0, 0, "R2 R4 abs", 1'b0);
        // R11: zero page, base high reads 0
        clr_patch(); patch(0, 16'h0480, 8'h9C);
        run_case(0, 0, 16'h0480, 0, 0, "R11 zp", 1'b0);
        // R3: zero page X wraps inside page zero
        clr_patch(); patch(0, 16'h0500, 8'hF0);
        run_case(1, 0, 16'h0500, 8'h20, 0, "R3 zpx wrap", 1'b0);
        // R3: zero page Y write
        clr_patch(); patch(0, 16'h0510, 8'h10);
        run_case(2, 1, 16'h0510, 8'h77, 8'h05, "R3 zpy", 1'b0);
        // R10: zero page read-modify-write
        clr_patch(); patch(0, 16'h0600, 8'h44); patch(1, 16'h0044, 8'hA5);
        run_case(0, 2, 16'h0600, 0, 0, "R10 zp rmw", 1'b0);
        // R5: abs X read, no cross
        clr_patch(); patch(0, 16'h0800, 8'h10); patch(1, 16'h0801, 8'h20);
        run_case(4, 0, 16'h0800, 8'h05, 0, "R5 absx nocross", 1'b0);
        // R6: abs X read, page cross
        clr_patch(); patch(0, 16'h0810, 8'hF0); patch(1, 16'h0811, 8'h20);
        run_case(4, 0, 16'h0810, 8'h20, 0, "R6 absx cross", 1'b0);
        // R6 R11: abs Y cross with 16-bit wrap
        clr_patch(); patch(0, 16'h0820, 8'hFF); patch(1, 16'h0821, 8'hFF);
        run_case(5, 0, 16'h0820, 0, 8'h01, "R6 R11 absy wrap", 1'b0);
        // R7: abs Y write, no cross still pays
        clr_patch(); patch(0, 16'h0830, 8'h10); patch(1, 16'h0831, 8'h20);
        run_case(5, 1, 16'h0830, 0, 8'h05, "R7 absy write", 1'b0);
        // R7 R10: abs X rmw, no cross and cross
        clr_patch(); patch(0, 16'h0840, 8'h10); patch(1, 16'h0841, 8'h30);
        run_case(4, 2, 16'h0840, 8'h01, 0, "R7 R10 absx rmw", 1'b0);
        clr_patch(); patch(0, 16'h0850, 8'hC0); patch(1, 16'h0851, 8'h30);
        run_case(4, 2, 16'h0850, 8'h50, 0, "R6 R10 absx rmw cross", 1'b0);
        // R8: pre-indexed with pointer wrap at 0xFF
        clr_patch(); patch(0, 16'h0700, 8'hFE); patch(1, 16'h00FF, 8'h78); patch(2, 16'h0000, 8'h56);
        run_case(6, 0, 16'h0700, 8'h01, 0, "R8 indx wrap", 1'b0);
        // R9: post-indexed, no cross, cross, rmw
        clr_patch(); patch(0, 16'h0710, 8'hFF); patch(1, 16'h00FF, 8'h78); patch(2, 16'h0000, 8'h56);
        run_case(7, 0, 16'h0710, 8'h33, 8'h02, "R9 R5 indy nocross", 1'b0);
        run_case(7, 0, 16'h0710, 8'h33, 8'h90, "R9 R6 indy cross", 1'b0);
        run_case(7, 2, 16'h0710, 8'h33, 8'h01, "R9 R7 R10 indy rmw", 1'b0);
        run_case(7, 1, 16'h0710, 8'h33, 8'h02, "R9 R7 indy write", 1'b0);
        // R12: start raised while busy has no effect
        clr_patch(); patch(0, 16'h0900, 8'h40); patch(1, 16'h0901, 8'h41);
        run_case(4, 1, 16'h0900, 8'h02, 0, "R12 R2 busy start", 1'b1);
        repeat (2) @(negedge clk);
        check_idle("R12 final");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule